// File: doc/BRIEF.md
# Gigabit Byte-Wide Transmit Framer

This block sits on the MAC side of a byte-wide gigabit media-independent link. It accepts frame contents (header and payload bytes) from a valid/ready stream that carries start and end markers. It produces the transmit byte bus together with its enable and error qualifiers, all registered on the 125 MHz transmit clock that the MAC also forwards to the PHY. One byte goes out per clock.

For every frame the block sends a preamble of seven 0x55 bytes and a 0xD5 delimiter. It then passes the stream bytes through unchanged and appends a four-byte Ethernet CRC-32. After each frame it holds the line idle for the minimum inter-frame gap. If the source aborts, or runs dry in the middle of a frame, the block marks the frame as corrupted on the error line and ends it at once.

Top module: `gbe_tx_framer`

## Requirements
- R1: While reset is asserted and on its release, tx_en_o, tx_er_o and s_ready_o are 0 and txd_o is 0x00.
- R2: When the block is idle, a stream byte offered with s_valid_i=1 and s_first_i=1 starts a frame. The first eight enabled bytes on txd_o are 0x55 seven times and then 0xD5.
- R3: s_ready_o is high only while the block accepts payload bytes or discards stray bytes. Starting from idle, a frame's first byte sees nine clocks of s_ready_o=0 (eight preamble/delimiter clocks plus the start clock). Accepted bytes appear on txd_o in order, one per clock, right after the delimiter.
- R4: After the byte accepted with s_last_i=1, four bytes follow. They carry the CRC-32 (reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, final bitwise inversion), computed over all accepted bytes, least significant byte first.
- R5: tx_en_o stays high without a break from the first preamble byte to the last CRC byte. A normal frame is therefore 12 plus its byte count clocks long. tx_er_o is low throughout a normal frame. txd_o is 0x00 whenever tx_en_o is low, and tx_er_o is never high while tx_en_o is low.
- R6: tx_en_o stays low for at least 12 clocks between frames. It stays low for exactly 12 clocks when the next frame is already waiting.
- R7: abort_i high during the preamble, delimiter, payload or CRC phase makes the next output byte carry tx_en_o=1, tx_er_o=1 and txd_o=0x00. That byte is the frame's last, and the gap of R6 follows it. The stream byte on offer during the abort is not accepted.
- R8: s_valid_i low while the block expects a payload byte ends the frame exactly as in R7.
- R9: abort_i while no frame is in progress has no effect: tx_en_o stays low.
- R10: In idle, a stream byte with s_first_i=0 is accepted (s_ready_o=1) and discarded, and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_first_i | input | 1 | Marks the first byte of a frame |
| s_last_i | input | 1 | Marks the last byte of a frame |
| s_ready_o | output | 1 | Stream byte accepted this clock when valid |
| abort_i | input | 1 | Request to corrupt and end the current frame |
| txd_o | output | 8 | Transmit byte bus |
| tx_en_o | output | 1 | Transmit enable |
| tx_er_o | output | 1 | Transmit error, marks the frame corrupted |

## Verification
The hardest case to reach from the ports is the exactly-12-clock gap: it appears only when the next frame's first byte is already on offer while the previous frame's CRC and gap are still going out. The bench presents each new frame as soon as the previous one has closed, so the next frame is waiting during the gap. Aborts are placed both inside the preamble and at a sweep of payload positions. Underruns are placed by dropping valid in the clock after a chosen byte is accepted.

// File: rtl/gbe_tx_pkg.sv
package gbe_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 32;
  localparam int CRC_BYTES = CRC_W / BYTE_W;
  localparam logic [BYTE_W-1:0] PRE_BYTE = 8'h55;
  localparam logic [BYTE_W-1:0] SFD_BYTE = 8'hD5;
  localparam logic [CRC_W-1:0]  CRC_POLY_R = 32'hEDB88320;
  localparam logic [CRC_W-1:0]  CRC_INIT   = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SFD, ST_DATA, ST_CRC, ST_GAP
  } tx_st_e;
endpackage

// File: rtl/gbe_tx_crc.sv
module gbe_tx_crc
  import gbe_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  fcs_o
);
  logic [CRC_W-1:0] crc_q, crc_nxt;

  always_comb begin
    crc_nxt = crc_q;
    for (int i = 0; i < BYTE_W; i++) begin
      if (crc_nxt[0] ^ byte_i[i]) crc_nxt = (crc_nxt >> 1) ^ CRC_POLY_R;
      else                        crc_nxt = crc_nxt >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (clr_i)  crc_q <= CRC_INIT;
    else if (upd_i)  crc_q <= crc_nxt;
  end

  assign fcs_o = ~crc_q;
endmodule

// File: rtl/gbe_tx_ctrl.sv
module gbe_tx_ctrl
  import gbe_tx_pkg::*;
#(
  parameter int PRE_LEN   = 7,
  parameter int GAP_BYTES = 12,
  localparam int CNT_W    = $clog2(PRE_LEN + GAP_BYTES + CRC_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_valid_i,
  input  logic              s_first_i,
  input  logic              s_last_i,
  input  logic              abort_i,
  input  logic [CRC_W-1:0]  fcs_i,
  output logic              s_ready_o,
  output logic              crc_clr_o,
  output logic              crc_upd_o,
  output logic [BYTE_W-1:0] dat_d_o,
  output logic              en_d_o,
  output logic              er_d_o,
  output tx_st_e            st_o
);
  tx_st_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active;

  assign active = (st_q == ST_PRE) || (st_q == ST_SFD) ||
                  (st_q == ST_DATA) || (st_q == ST_CRC);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    s_ready_o = 1'b0;
    crc_clr_o = 1'b0;
    crc_upd_o = 1'b0;
    dat_d_o   = '0;
    en_d_o    = 1'b0;
    er_d_o    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        s_ready_o = s_valid_i && !s_first_i;  // stray bytes dropped
        if (s_valid_i && s_first_i) begin
          st_d      = ST_PRE;
          cnt_d     = '0;
          crc_clr_o = 1'b1;
        end
      end
      ST_PRE: begin
        en_d_o  = 1'b1;
        dat_d_o = PRE_BYTE;
        if (cnt_q == CNT_W'(PRE_LEN - 1)) st_d = ST_SFD;
        else                              cnt_d = cnt_q + 1'b1;
      end
      ST_SFD: begin
        en_d_o  = 1'b1;
        dat_d_o = SFD_BYTE;
        st_d    = ST_DATA;
      end
      ST_DATA: begin
        s_ready_o = 1'b1;
        en_d_o    = 1'b1;
        if (s_valid_i) begin
          dat_d_o   = s_data_i;
          crc_upd_o = 1'b1;
          if (s_last_i) begin
            st_d  = ST_CRC;
            cnt_d = '0;
          end
        end else begin
          // underrun: corrupt and close
          er_d_o = 1'b1;
          st_d   = ST_GAP;
          cnt_d  = '0;
        end
      end
      ST_CRC: begin
        en_d_o  = 1'b1;
        dat_d_o = fcs_i[{cnt_q[1:0], 3'b000} +: BYTE_W];
        if (cnt_q == CNT_W'(CRC_BYTES - 1)) begin
          st_d  = ST_GAP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        // IDLE clock plus GAP_BYTES-1 gap clocks give the full gap
        if (cnt_q == CNT_W'(GAP_BYTES - 2)) st_d = ST_IDLE;
        else                                cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase

    if (abort_i && active) begin
      s_ready_o = 1'b0;
      crc_upd_o = 1'b0;
      en_d_o    = 1'b1;
      er_d_o    = 1'b1;
      dat_d_o   = '0;
      st_d      = ST_GAP;
      cnt_d     = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/gbe_tx_outreg.sv
module gbe_tx_outreg
  import gbe_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] dat_i,
  input  logic              en_i,
  input  logic              er_i,
  output logic [BYTE_W-1:0] txd_o,
  output logic              tx_en_o,
  output logic              tx_er_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_o   <= '0;
      tx_en_o <= 1'b0;
      tx_er_o <= 1'b0;
    end else begin
      txd_o   <= dat_i;
      tx_en_o <= en_i;
      tx_er_o <= er_i;
    end
  end
endmodule

// File: rtl/gbe_tx_framer.sv
module gbe_tx_framer
  import gbe_tx_pkg::*;
#(
  parameter int PRE_LEN   = 7,
  parameter int GAP_BYTES = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_first_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  input  logic       abort_i,
  output logic [7:0] txd_o,
  output logic       tx_en_o,
  output logic       tx_er_o
);
  logic              crc_clr, crc_upd;
  logic [CRC_W-1:0]  fcs;
  logic [BYTE_W-1:0] dat_d;
  logic              en_d, er_d;
  tx_st_e            st_q;

  gbe_tx_ctrl #(.PRE_LEN(PRE_LEN), .GAP_BYTES(GAP_BYTES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_data_i  (s_data_i),
    .s_valid_i (s_valid_i),
    .s_first_i (s_first_i),
    .s_last_i  (s_last_i),
    .abort_i   (abort_i),
    .fcs_i     (fcs),
    .s_ready_o (s_ready_o),
    .crc_clr_o (crc_clr),
    .crc_upd_o (crc_upd),
    .dat_d_o   (dat_d),
    .en_d_o    (en_d),
    .er_d_o    (er_d),
    .st_o      (st_q)
  );

  gbe_tx_crc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .upd_i  (crc_upd),
    .byte_i (s_data_i),
    .fcs_o  (fcs)
  );

  gbe_tx_outreg u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dat_i   (dat_d),
    .en_i    (en_d),
    .er_i    (er_d),
    .txd_o   (txd_o),
    .tx_en_o (tx_en_o),
    .tx_er_o (tx_er_o)
  );
endmodule

// File: rtl/gbe_tx_framer_chk.sv
module gbe_tx_framer_chk
  import gbe_tx_pkg::*;
#(
  parameter int GAP_BYTES = 12
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       s_ready_o,
  input logic       abort_i,
  input logic [7:0] txd_o,
  input logic       tx_en_o,
  input logic       tx_er_o,
  input tx_st_e     st_i
);
  localparam int IC_W = $clog2(GAP_BYTES + 1) + 1;
  logic [IC_W-1:0] idle_cnt;
  logic            active;

  assign active = (st_i == ST_PRE) || (st_i == ST_SFD) ||
                  (st_i == ST_DATA) || (st_i == ST_CRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  idle_cnt <= IC_W'(GAP_BYTES);
    else if (tx_en_o)                             idle_cnt <= '0;
    else if (idle_cnt < IC_W'(GAP_BYTES))         idle_cnt <= idle_cnt + 1'b1;
  end

  // R5
  er_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_er_o |-> tx_en_o);
  // R5
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> (txd_o == 8'h00));
  // R2
  pre_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> (txd_o == PRE_BYTE));
  // R3
  ready_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (st_i == ST_IDLE || st_i == ST_DATA));
  // R6
  gap_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> (idle_cnt >= IC_W'(GAP_BYTES)));
  // R7
  abort_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && active) |=> (tx_en_o && tx_er_o && txd_o == 8'h00));
  // R9
  idle_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && st_i == ST_IDLE) |=> !tx_en_o);
endmodule

bind gbe_tx_framer gbe_tx_framer_chk #(.GAP_BYTES(GAP_BYTES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .s_ready_o (s_ready_o),
  .abort_i   (abort_i),
  .txd_o     (txd_o),
  .tx_en_o   (tx_en_o),
  .tx_er_o   (tx_er_o),
  .st_i      (st_q)
);

// File: tb/gbe_tx_framer_tb.sv
`timescale 1ns/1ps
module gbe_tx_framer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] s_data_i = '0;
  logic       s_valid_i = 1'b0, s_first_i = 1'b0, s_last_i = 1'b0, abort_i = 1'b0;
  logic       s_ready_o, tx_en_o, tx_er_o;
  logic [7:0] txd_o;

  gbe_tx_framer dut_i (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor
  logic [7:0] mon_d [0:511];
  bit         mon_e [0:511];
  int  cur_len = 0, mon_len = 0, idle_run = 0, last_gap = 0, n_frames = 0;
  int  bad_idle = 0;
  bit  prev_en = 0, frame_done = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (tx_en_o) begin
        if (!prev_en) begin
          last_gap = idle_run;
          idle_run = 0;
          cur_len  = 0;
        end
        if (cur_len < 512) begin
          mon_d[cur_len] = txd_o;
          mon_e[cur_len] = tx_er_o;
        end
        cur_len++;
      end else begin
        if (prev_en) begin
          mon_len = cur_len;
          n_frames++;
          frame_done = 1;
        end
        idle_run++;
        if (txd_o != 8'h00 || tx_er_o) bad_idle++;
      end
      prev_en = tx_en_o;
    end
  end

  function automatic logic [7:0] pay(input int len, input int i);
    return 8'((i * 37 + len * 11 + 3) & 255);
  endfunction

  function automatic logic [31:0] fcs_of(input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      c = c ^ {24'h0, pay(len, i)};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  int wait0;

  // err_at: byte index at which to abort (mode 1) or underrun (mode 2); mode 0 normal
  task automatic send_frame(input int len, input int mode, input int err_at);
    for (int i = 0; i < len; i++) begin
      if (mode == 1 && i == err_at) begin
        s_valid_i = 1; s_data_i = pay(len, i); s_first_i = 0; s_last_i = 0;
        abort_i = 1;
        @(negedge clk_i);
        abort_i = 0; s_valid_i = 0;
        return;
      end
      if (mode == 2 && i == err_at) begin
        s_valid_i = 0; s_first_i = 0; s_last_i = 0;
        @(negedge clk_i);
        return;
      end
      s_valid_i = 1; s_data_i = pay(len, i);
      s_first_i = (i == 0); s_last_i = (i == len - 1);
      if (i == 0) wait0 = 0;
      #1;
      while (!s_ready_o) begin
        @(negedge clk_i); #1;
        if (i == 0) wait0++;
      end
      @(negedge clk_i);
    end
    s_valid_i = 0; s_first_i = 0; s_last_i = 0;
  endtask

  task automatic wait_frame();
    while (!frame_done) @(negedge clk_i);
    frame_done = 0;
  endtask

  task automatic check_normal(input int len, input bit gap_exact);
    int pre_bad = 0, pay_bad = 0, er_cnt = 0;
    logic [31:0] f = fcs_of(len);
    logic [31:0] got;
    chk(mon_len == len + 12, "R5", "frame length", mon_len, len + 12);
    for (int i = 0; i < 7; i++) if (mon_d[i] != 8'h55) pre_bad++;
    chk(pre_bad == 0, "R2", "preamble bytes wrong", pre_bad, 0);
    chk(mon_d[7] == 8'hD5, "R2", "delimiter", mon_d[7], 8'hD5);
    for (int i = 0; i < len; i++) if (mon_d[8 + i] != pay(len, i)) pay_bad++;
    chk(pay_bad == 0, "R3", "payload bytes wrong", pay_bad, 0);
    got = {mon_d[len + 11], mon_d[len + 10], mon_d[len + 9], mon_d[len + 8]};
    chk(got == f, "R4", "crc lsb first", got, f);
    for (int i = 0; i < len + 12; i++) if (mon_e[i]) er_cnt++;
    chk(er_cnt == 0, "R5", "error flags in normal frame", er_cnt, 0);
    if (gap_exact) chk(last_gap == 12, "R6", "gap with waiting frame", last_gap, 12);
    else           chk(last_gap >= 12, "R6", "minimum gap", last_gap, 12);
  endtask

  task automatic check_err(input string req, input int k);
    int bad = 0;
    chk(mon_len == k + 9, req, "corrupted frame length", mon_len, k + 9);
    for (int i = 0; i < k + 8; i++) if (mon_e[i]) bad++;
    chk(bad == 0, req, "early error flags", bad, 0);
    chk(mon_e[k + 8] && mon_d[k + 8] == 8'h00, req, "final byte marked",
        {mon_e[k + 8], mon_d[k + 8]}, 9'h100);
    chk(mon_d[k + 7] == (k == 0 ? 8'hD5 : pay(20, k - 1)), req, "byte before mark",
        mon_d[k + 7], (k == 0 ? 8'hD5 : pay(20, k - 1)));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (5) @(negedge clk_i);
    // R1 during reset
    chk(!tx_en_o && !tx_er_o && txd_o == 0 && !s_ready_o, "R1", "outputs in reset",
        {tx_en_o, tx_er_o, s_ready_o, txd_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!tx_en_o && !tx_er_o && txd_o == 0 && !s_ready_o, "R1", "outputs after reset",
        {tx_en_o, tx_er_o, s_ready_o, txd_o}, 0);

    // R9: abort while idle
    abort_i = 1;
    repeat (3) @(negedge clk_i);
    abort_i = 0;
    repeat (3) @(negedge clk_i);
    chk(n_frames == 0 && !tx_en_o, "R9", "abort in idle started output", n_frames, 0);

    // R10: stray bytes discarded
    s_valid_i = 1; s_first_i = 0;
    for (int i = 0; i < 4; i++) begin
      s_data_i = 8'(i + 1);
      #1;
      chk(s_ready_o == 1, "R10", "stray byte not accepted", s_ready_o, 1);
      @(negedge clk_i);
    end
    s_valid_i = 0;
    repeat (4) @(negedge clk_i);
    chk(n_frames == 0 && !tx_en_o, "R10", "stray byte started frame", n_frames, 0);

    // R3: first byte waits nine clocks from idle
    send_frame(1, 0, 0);
    chk(wait0 == 9, "R3", "ready low clocks before payload", wait0, 9);
    wait_frame();
    check_normal(1, 0);

    // R2..R6 sweep, next frame offered while gap runs
    for (int len = 2; len <= 64; len++) begin
      send_frame(len, 0, 0);
      wait_frame();
      check_normal(len, 1);
    end
    send_frame(300, 0, 0);
    wait_frame();
    check_normal(300, 1);

    // R7: abort at payload positions
    for (int k = 1; k <= 10; k++) begin
      send_frame(20, 1, k);
      wait_frame();
      check_err("R7", k);
    end

    // R8: underrun after k bytes
    for (int k = 1; k <= 5; k++) begin
      send_frame(20, 2, k);
      wait_frame();
      check_err("R8", k);
    end

    // R7: abort in preamble
    repeat (20) @(negedge clk_i);
    s_valid_i = 1; s_first_i = 1; s_data_i = 8'hAA;
    @(negedge clk_i);
    s_valid_i = 0; s_first_i = 0;
    @(negedge clk_i);
    abort_i = 1;
    @(negedge clk_i);
    abort_i = 0;
    wait_frame();
    chk(mon_len == 2 && mon_d[0] == 8'h55 && !mon_e[0] && mon_e[1] && mon_d[1] == 0,
        "R7", "abort in preamble", {mon_len, mon_d[1], mon_e[1]}, {32'd2, 8'h00, 1'b1});

    // recovery, then R9 during gap-free idle again
    f0 = n_frames;
    send_frame(17, 0, 0);
    wait_frame();
    check_normal(17, 0);
    repeat (20) @(negedge clk_i);
    abort_i = 1; @(negedge clk_i); abort_i = 0;
    repeat (4) @(negedge clk_i);
    chk(n_frames == f0 + 1 && !tx_en_o, "R9", "late idle abort", n_frames, f0 + 1);

    chk(bad_idle == 0, "R5", "idle bus not zero", bad_idle, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule